// File: doc/BRIEF.md
# Reverse-Subtract Execution Unit

This unit carries out the two reverse-subtract operations of a small accumulator-style core. Both subtract the working register (W) from a second operand. In the immediate form the operand is the low byte of the instruction word. In the memory form the operand is a byte in an internal register file. The unit writes the difference and a five-bit status word.

An instruction is launched with a one-cycle `start` pulse while the unit is idle. It then walks through four phases: decode, operand fetch, compute and commit. `busy` stays high through all four phases. The operand address in the memory form comes from one of three places: a fixed access window, the bank register joined with the offset, or an index pointer plus the offset.

The physical file holds 2^PHYS_W bytes and is indexed by the low bits of the logical address. With the default of 512 bytes, bank 0 and bank 15 land in different halves. All locations clear to zero on reset. W and the bank register can be preloaded from the ports only while the unit is idle.

Top module: `sub_exec_unit`

## Requirements
- R1: A word whose upper byte is 08h (immediate form) loads W with (low byte − W) mod 256 and never writes the register file.
- R2: A word whose upper six bits are 010111 (memory form, bit 9 = d, bit 8 = a, bits 7:0 = f) computes (file[addr] − W) mod 256. With d=0 the result goes to W and the file is unchanged. With d=1 the result goes to the file location and W is unchanged.
- R3: Status bit 0 (carry) is 1 when the operand is at least W, meaning no borrow, and 0 otherwise.
- R4: Status bit 2 (zero) is 1 exactly when the 8-bit result is 00h, and status bit 4 (negative) equals result bit 7.
- R5: Status bit 1 (digit carry) is 1 when the operand's low nibble is at least W's low nibble.
- R6: Status bit 3 (overflow) is 1 when the signed difference of the two bytes lies outside −128..127.
- R7: With a=0 and the extended-mode input low, an offset below 60h addresses bank 0 at that offset, and any other offset addresses bank 15.
- R8: With a=1, the logical address is the 4-bit bank register followed by f.
- R9: With the extended-mode input high, a=0 and f at most 5Fh, the address is idx_ptr + f. A larger f falls back to the R7 mapping.
- R10: An accepted start raises busy for exactly four cycles. Results are visible in the cycle after busy falls. A start while busy is ignored.
- R11: A word that matches neither form sets `illegal` and leaves W, status and the file unchanged. The next accepted start clears `illegal`.
- R12: Reset clears W, the bank register, status, `illegal`, `busy` and every file byte. The W and bank loads take effect only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch the instruction on `instr` |
| instr | input | 16 | Instruction word |
| ext_mode | input | 1 | Enables indexed addressing |
| idx_ptr | input | 8 | Index pointer for indexed addressing |
| w_load | input | 1 | Preload W (idle only) |
| w_load_val | input | 8 | Value for W preload |
| bsr_load | input | 1 | Preload bank register (idle only) |
| bsr_load_val | input | 4 | Value for bank preload |
| busy | output | 1 | High during the four phases |
| illegal | output | 1 | Last instruction was not recognised |
| w_out | output | 8 | Working register |
| status_out | output | 5 | {N, OV, Z, DC, C}, carry in bit 0 |

## Verification
The bench targets the borrow edges: operand equal to W, operand one below W, equal low nibbles, and sign-crossing pairs near 7Fh/80h. A design that inverts carry, tests digit carry strictly, or derives overflow from the wrong operand's sign fails there. Random memory-form runs mix every d/a/extended combination with offsets on both sides of 5Fh. They read locations back through W, so an address built from the wrong bank, a missing fallback, or a write to the wrong destination shows up as a wrong value. Starts and W loads issued mid-instruction, and unrecognised words, catch a sequencer that restarts, accepts loads while busy, or commits garbage.

// File: rtl/sub_exec_pkg.sv
`timescale 1ns/1ps
package sub_exec_pkg;
  localparam logic [7:0] LIT_OPC = 8'h08;
  localparam logic [5:0] MEM_OPC = 6'b010111;

  localparam int ST_C  = 0;
  localparam int ST_DC = 1;
  localparam int ST_Z  = 2;
  localparam int ST_OV = 3;
  localparam int ST_N  = 4;
  localparam int ST_W  = 5;

  typedef enum logic [2:0] {PH_IDLE, PH_Q1, PH_Q2, PH_Q3, PH_Q4} phase_e;
  typedef enum logic [1:0] {OP_NONE, OP_LIT, OP_MEM} op_kind_e;

  typedef struct packed {
    logic [7:0]      res;
    logic [ST_W-1:0] flags;
  } sub_out_t;

  // operand minus W with borrow-style flags
  function automatic sub_out_t sub_eval(input logic [7:0] opnd, input logic [7:0] wv);
    logic [8:0] full;
    logic [4:0] low;
    sub_out_t   o;
    full = {1'b0, opnd} - {1'b0, wv};
    low  = {1'b0, opnd[3:0]} - {1'b0, wv[3:0]};
    o.res           = full[7:0];
    o.flags[ST_C]   = ~full[8];
    o.flags[ST_DC]  = ~low[4];
    o.flags[ST_Z]   = (full[7:0] == 8'h00);
    o.flags[ST_N]   = full[7];
    o.flags[ST_OV]  = (opnd[7] ^ wv[7]) & (full[7] ^ opnd[7]);
    return o;
  endfunction
endpackage

// File: rtl/sub_exec_seq.sv
`timescale 1ns/1ps
module sub_exec_seq
  import sub_exec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase,
  output logic   accept,
  output logic   busy
);
  phase_e phase_nx;

  assign accept = (phase == PH_IDLE) && start;
  assign busy   = (phase != PH_IDLE);

  always_comb begin
    unique case (phase)
      PH_IDLE: phase_nx = start ? PH_Q1 : PH_IDLE;
      PH_Q1:   phase_nx = PH_Q2;
      PH_Q2:   phase_nx = PH_Q3;
      PH_Q3:   phase_nx = PH_Q4;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end
endmodule

// File: rtl/sub_exec_decode.sv
`timescale 1ns/1ps
module sub_exec_decode
  import sub_exec_pkg::*;
#(
  parameter int         BANK_W    = 4,
  parameter logic [7:0] ACC_SPLIT = 8'h60,
  localparam int        ADDR_W    = BANK_W + 8
) (
  input  logic [15:0]       iw,
  input  logic              ext_mode,
  input  logic [BANK_W-1:0] bank,
  input  logic [7:0]        idx_ptr,
  output op_kind_e          kind,
  output logic              dest_mem,
  output logic [7:0]        literal,
  output logic [ADDR_W-1:0] addr
);
  logic [7:0]        f;
  logic              a_bit;
  logic              low_window;
  logic              use_index;
  logic [ADDR_W-1:0] acc_addr;
  logic [ADDR_W-1:0] bnk_addr;
  logic [ADDR_W-1:0] idx_addr;

  assign f          = iw[7:0];
  assign a_bit      = iw[8];
  assign literal    = iw[7:0];
  assign low_window = (f < ACC_SPLIT);
  assign use_index  = ext_mode && !a_bit && low_window;

  always_comb begin
    if (iw[15:8] == LIT_OPC)       kind = OP_LIT;
    else if (iw[15:10] == MEM_OPC) kind = OP_MEM;
    else                           kind = OP_NONE;
  end

  assign dest_mem = (kind == OP_MEM) && iw[9];

  assign acc_addr = low_window ? {{BANK_W{1'b0}}, f} : {{BANK_W{1'b1}}, f};
  assign bnk_addr = {bank, f};
  assign idx_addr = {{BANK_W{1'b0}}, idx_ptr} + {{BANK_W{1'b0}}, f};

  always_comb begin
    if (a_bit)          addr = bnk_addr;
    else if (use_index) addr = idx_addr;
    else                addr = acc_addr;
  end
endmodule

// File: rtl/sub_exec_rf.sv
`timescale 1ns/1ps
module sub_exec_rf #(
  parameter int  ADDR_W = 12,
  parameter int  PHYS_W = 9,
  localparam int DEPTH  = 1 << PHYS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data
);
  logic [7:0]        mem [DEPTH];
  logic [PHYS_W-1:0] rd_idx;
  logic [PHYS_W-1:0] wr_idx;

  assign rd_idx = rd_addr[PHYS_W-1:0];
  assign wr_idx = wr_addr[PHYS_W-1:0];

  generate
    if (PHYS_W < ADDR_W) begin : g_fold
      logic unused_hi;
      assign unused_hi = ^{rd_addr[ADDR_W-1:PHYS_W], wr_addr[ADDR_W-1:PHYS_W]};
    end
  endgenerate

  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/sub_exec_unit.sv
`timescale 1ns/1ps
module sub_exec_unit
  import sub_exec_pkg::*;
#(
  parameter int         BANK_W    = 4,
  parameter int         PHYS_W    = 9,
  parameter logic [7:0] ACC_SPLIT = 8'h60,
  localparam int        ADDR_W    = BANK_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       instr,
  input  logic              ext_mode,
  input  logic [7:0]        idx_ptr,
  input  logic              w_load,
  input  logic [7:0]        w_load_val,
  input  logic              bsr_load,
  input  logic [BANK_W-1:0] bsr_load_val,
  output logic              busy,
  output logic              illegal,
  output logic [7:0]        w_out,
  output logic [ST_W-1:0]   status_out
);
  phase_e            phase;
  logic              accept;
  logic [15:0]       instr_q;
  logic [BANK_W-1:0] bsr_q;
  logic [7:0]        w_q;
  logic [ST_W-1:0]   status_q;
  logic              illegal_q;

  op_kind_e          dec_kind;
  logic              dec_dest_mem;
  logic [7:0]        dec_lit;
  logic [ADDR_W-1:0] dec_addr;

  op_kind_e          kind_q;
  logic              dest_mem_q;
  logic [7:0]        lit_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        opnd_q;
  sub_out_t          calc_q;
  logic [7:0]        rf_rd_data;

  // named events for the checker
  logic q4_commit;
  logic w_we;
  logic mem_we;
  logic flag_we;
  logic illegal_hit;
  logic idle;

  sub_exec_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .phase  (phase),
    .accept (accept),
    .busy   (busy)
  );

  sub_exec_decode #(.BANK_W(BANK_W), .ACC_SPLIT(ACC_SPLIT)) u_dec (
    .iw       (instr_q),
    .ext_mode (ext_mode),
    .bank     (bsr_q),
    .idx_ptr  (idx_ptr),
    .kind     (dec_kind),
    .dest_mem (dec_dest_mem),
    .literal  (dec_lit),
    .addr     (dec_addr)
  );

  sub_exec_rf #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (addr_q),
    .rd_data (rf_rd_data),
    .we      (mem_we),
    .wr_addr (addr_q),
    .wr_data (calc_q.res)
  );

  assign idle        = (phase == PH_IDLE);
  assign q4_commit   = (phase == PH_Q4) && (kind_q != OP_NONE);
  assign illegal_hit = (phase == PH_Q4) && (kind_q == OP_NONE);
  assign mem_we      = q4_commit && (kind_q == OP_MEM) && dest_mem_q;
  assign w_we        = q4_commit && !mem_we;
  assign flag_we     = q4_commit;

  // latch word at accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      instr_q <= 16'h0000;
    else if (accept) instr_q <= instr;
  end

  // Q1: decode results captured
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q     <= OP_NONE;
      dest_mem_q <= 1'b0;
      lit_q      <= 8'h00;
      addr_q     <= '0;
    end else if (phase == PH_Q1) begin
      kind_q     <= dec_kind;
      dest_mem_q <= dec_dest_mem;
      lit_q      <= dec_lit;
      addr_q     <= dec_addr;
    end
  end

  // Q2: operand fetch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 opnd_q <= 8'h00;
    else if (phase == PH_Q2)    opnd_q <= (kind_q == OP_LIT) ? lit_q : rf_rd_data;
  end

  // Q3: compute
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 calc_q <= '0;
    else if (phase == PH_Q3)    calc_q <= sub_eval(opnd_q, w_q);
  end

  // Q4: commit; idle-time preloads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q      <= 8'h00;
      bsr_q    <= '0;
      status_q <= '0;
    end else begin
      if (w_we)                w_q <= calc_q.res;
      else if (idle && w_load) w_q <= w_load_val;
      if (idle && bsr_load)    bsr_q <= bsr_load_val;
      if (flag_we)             status_q <= calc_q.flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           illegal_q <= 1'b0;
    else if (accept)      illegal_q <= 1'b0;
    else if (illegal_hit) illegal_q <= 1'b1;
  end

  assign illegal    = illegal_q;
  assign w_out      = w_q;
  assign status_out = status_q;
endmodule

// File: rtl/sub_exec_chk.sv
`timescale 1ns/1ps
module sub_exec_chk
  import sub_exec_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input phase_e          phase,
  input op_kind_e        kind_q,
  input logic            w_we,
  input logic            mem_we,
  input logic            flag_we,
  input logic            illegal_hit,
  input logic            illegal,
  input logic [7:0]      w_out,
  input logic [ST_W-1:0] status_out
);
  a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r10_q4_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_Q4) |=> !busy);

  a_r10_w_stable_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_Q1 || phase == PH_Q2 || phase == PH_Q3) |=> $stable(w_out));

  a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_hit |=> ($stable(w_out) && $stable(status_out) && illegal));

  a_r3_zero_has_carry: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (!status_out[ST_Z] || status_out[ST_C]));

  a_r4_sign_tracks_w: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && w_we) |=> (status_out[ST_N] == w_out[7]));

  a_r1_lit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_Q4) && (kind_q == OP_LIT)) |-> !mem_we);
endmodule

bind sub_exec_unit sub_exec_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .phase       (phase),
  .kind_q      (kind_q),
  .w_we        (w_we),
  .mem_we      (mem_we),
  .flag_we     (flag_we),
  .illegal_hit (illegal_hit),
  .illegal     (illegal),
  .w_out       (w_out),
  .status_out  (status_out)
);

// File: tb/sub_exec_unit_tb_top.sv
`timescale 1ns/1ps
module sub_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic        ext_mode = 1'b0;
  logic [7:0]  idx_ptr = 8'h00;
  logic        w_load = 1'b0;
  logic [7:0]  w_load_val = 8'h00;
  logic        bsr_load = 1'b0;
  logic [3:0]  bsr_load_val = 4'h0;
  logic        busy;
  logic        illegal;
  logic [7:0]  w_out;
  logic [4:0]  status_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] m_mem [512];
  logic [7:0] m_w = 8'h00;
  logic [3:0] m_bsr = 4'h0;
  logic [4:0] m_st = 5'h00;
  logic       m_ill = 1'b0;

  always #2 clk = ~clk;

  sub_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .ext_mode(ext_mode), .idx_ptr(idx_ptr),
    .w_load(w_load), .w_load_val(w_load_val),
    .bsr_load(bsr_load), .bsr_load_val(bsr_load_val),
    .busy(busy), .illegal(illegal), .w_out(w_out), .status_out(status_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // physical index from the addressing rules (512-byte file)
  function automatic int model_addr(input int f, input int a);
    int full;
    if (a == 1)                          full = int'(m_bsr) * 256 + f;
    else if (ext_mode && f <= 95)        full = int'(idx_ptr) + f;
    else if (f < 96)                     full = f;
    else                                 full = 15 * 256 + f;
    return full % 512;
  endfunction

  task automatic ref_sub(input int op, input int wv, output logic [7:0] r, output logic [4:0] fl);
    int d, so, sw, sd;
    d  = op - wv;
    r  = 8'((d < 0) ? d + 256 : d);
    so = (op >= 128) ? op - 256 : op;
    sw = (wv >= 128) ? wv - 256 : wv;
    sd = so - sw;
    fl[0] = (op >= wv);
    fl[1] = ((op % 16) >= (wv % 16));
    fl[2] = (r == 0);
    fl[3] = (sd > 127) || (sd < -128);
    fl[4] = (r >= 128);
  endtask

  task automatic load_w(input logic [7:0] v);
    @(negedge clk); w_load = 1'b1; w_load_val = v;
    @(negedge clk); w_load = 1'b0;
    m_w = v;
  endtask

  task automatic load_bsr(input logic [3:0] v);
    @(negedge clk); bsr_load = 1'b1; bsr_load_val = v;
    @(negedge clk); bsr_load = 1'b0;
    m_bsr = v;
  endtask

  task automatic exec_op(input logic [15:0] iw, input string tag);
    int op, adr;
    logic lit, memf;
    logic [7:0] r;
    logic [4:0] fl;
    lit  = (iw[15:8] == 8'h08);
    memf = (iw[15:10] == 6'b010111);
    adr  = 0;
    op   = 0;
    if (lit) op = int'(iw[7:0]);
    else if (memf) begin
      adr = model_addr(int'(iw[7:0]), int'(iw[8]));
      op  = int'(m_mem[adr]);
    end
    m_ill = !(lit || memf);
    if (!m_ill) begin
      ref_sub(op, int'(m_w), r, fl);
      m_st = fl;
      if (memf && iw[9]) m_mem[adr] = r;
      else               m_w = r;
    end
    @(negedge clk); instr = iw; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk({tag, " W"}, int'(w_out), int'(m_w));
    chk("R3 carry", int'(status_out[0]), int'(m_st[0]));
    chk("R5 digit carry", int'(status_out[1]), int'(m_st[1]));
    chk("R4 zero", int'(status_out[2]), int'(m_st[2]));
    chk("R6 overflow", int'(status_out[3]), int'(m_st[3]));
    chk("R4 negative", int'(status_out[4]), int'(m_st[4]));
    chk("R11 illegal", int'(illegal), int'(m_ill));
  endtask

  task automatic ex_check(input string tag, input int w_e, input int c, input int z, input int n);
    chk({tag, " R1/R2 value"}, int'(w_out), w_e);
    chk({tag, " R3 C"}, int'(status_out[0]), c);
    chk({tag, " R4 Z"}, int'(status_out[2]), z);
    chk({tag, " R4 N"}, int'(status_out[4]), n);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) m_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 W reset", int'(w_out), 0);
    chk("R12 status reset", int'(status_out), 0);
    chk("R12 busy reset", int'(busy), 0);
    chk("R12 illegal reset", int'(illegal), 0);
    exec_op(16'h5C10, "R12 mem zero");
    chk("R12 zero-read flags", int'(status_out), 7);
    exec_op(16'h5D33, "R12 mem zero banked");

    // immediate-form examples (R1)
    load_w(8'h01); exec_op(16'h0802, "R1 ex1"); ex_check("ex1", 8'h01, 1, 0, 0);
    load_w(8'h02); exec_op(16'h0802, "R1 ex2"); ex_check("ex2", 8'h00, 1, 1, 0);
    load_w(8'h03); exec_op(16'h0802, "R1 ex3"); ex_check("ex3", 8'hFF, 0, 0, 1);

    // memory-form examples (R2)
    load_w(8'hFD); exec_op(16'h5E20, "R2 seed");
    load_w(8'h02); exec_op(16'h5E20, "R2 ex1 d1"); ex_check("R2 ex1", 8'h02, 1, 0, 0);
    load_w(8'h00); exec_op(16'h5C20, "R2 readback"); chk("R2 ex1 mem", int'(w_out), 1);
    load_w(8'hFE); exec_op(16'h5E21, "R2 seed");
    load_w(8'h02); exec_op(16'h5C21, "R2 ex2 d0"); ex_check("R2 ex2", 8'h00, 1, 1, 0);
    load_w(8'hFF); exec_op(16'h5E22, "R2 seed");
    load_w(8'h02); exec_op(16'h5E22, "R2 ex3 d1"); ex_check("R2 ex3", 8'h02, 0, 0, 1);
    load_w(8'h00); exec_op(16'h5C22, "R2 readback"); chk("R2 ex3 mem", int'(w_out), 8'hFF);

    // R1 sweep: every literal against 16 W values
    for (int wi = 0; wi < 16; wi++) begin
      for (int k = 0; k < 256; k++) begin
        load_w(8'(wi * 17 + (k & 1)));
        exec_op({8'h08, 8'(k)}, "R1 sweep");
      end
    end

    // R2 R7 R8 R9: random memory-form mix
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] da;
      logic [7:0] f;
      string tg;
      da = 2'($urandom_range(0, 3));
      f  = 8'($urandom_range(0, 255));
      ext_mode = ($urandom_range(0, 1) == 1);
      idx_ptr  = 8'($urandom_range(0, 255));
      load_bsr(4'($urandom_range(0, 15)));
      load_w(8'($urandom_range(0, 255)));
      if (da[0])                        tg = "R8 banked";
      else if (ext_mode && f <= 8'h5F)  tg = "R9 indexed";
      else                              tg = "R7 access";
      exec_op({6'b010111, da, f}, {"R2 ", tg});
    end
    ext_mode = 1'b0;

    // R10 timing, start and loads ignored while busy (R12)
    load_w(8'h05);
    @(negedge clk); instr = 16'h0809; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10 busy Q1", int'(busy), 1);
    @(negedge clk); instr = 16'h08AA; start = 1'b1; w_load = 1'b1; w_load_val = 8'h77;
    chk("R10 busy Q2", int'(busy), 1);
    @(negedge clk); start = 1'b0; w_load = 1'b0;
    chk("R10 busy Q3", int'(busy), 1);
    @(negedge clk);
    chk("R10 busy Q4", int'(busy), 1);
    @(negedge clk);
    chk("R10 busy done", int'(busy), 0);
    chk("R10 result", int'(w_out), 4);
    chk("R12 load ignored busy", int'(w_out), 4);
    @(negedge clk);
    chk("R10 no restart", int'(busy), 0);
    m_w = 8'h04; m_st = 5'b00011;

    // R11 unrecognised words
    exec_op(16'hFFFF, "R11 ffff");
    chk("R11 flag set", int'(illegal), 1);
    exec_op(16'h0900, "R11 0900");
    exec_op(16'h5000, "R11 5000");
    exec_op(16'h0806, "R11 cleared");
    chk("R11 flag cleared", int'(illegal), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule